// File: doc/BRIEF.md
# Pipelined Signed Fractional Divider

This block divides a 15-bit unsigned numerator by a 15-bit unsigned denominator that is at least as large, and returns the quotient as a pure fraction in 16-bit two's complement form. A sign flag travels with the numerator. At the output it turns the unsigned fraction into a signed value. A typical use is scaling each component of a vector by the vector's length, one component per divider.

The division is non-restoring. The first trial compares the numerator with half the denominator. Each later step adds or subtracts the next halved denominator, chosen by the previous quotient bit. The remainder never exceeds the denominator, so every stage uses the same 17-bit adder. Every pipeline stage settles exactly one quotient bit, with weights from 2^-1 down to 2^-15. The last remainder is dropped.

The block accepts one operand pair on every clock. A valid flag travels through the pipeline with the data. The result appears 16 cycles after the operands are captured: 15 quotient stages and one sign-conversion stage. Operands with the numerator larger than the denominator, or with a zero denominator, are outside the block's defined range.

Top module: `nrdiv_frac_pipe`

## Requirements
- R1: For a numerator t below the denominator D, with the sign flag clear, the output equals floor(t * 2^15 / D).
- R2: When t equals D, the output is 0x7FFF with the sign flag clear and 0x8001 with it set. The fraction saturates at 0.111111111111111 and never reaches 1.
- R3: With the sign flag set, the output is the two's complement negation of the R1 magnitude. Bit 15 carries weight -1 and bits 14..0 carry weights 2^-1..2^-15.
- R4: A zero numerator with the sign flag set gives 0x0000, not a negative value.
- R5: A new operand pair is accepted on every clock without stalls. Each result appears on `res_val` exactly 16 cycles after its operands were captured.
- R6: `res_vld` is high in exactly those cycles that follow a captured `op_vld` by 16 cycles. A cycle with `op_vld` low produces no result.
- R7: While `rst_n` is low, and after its release until the first result arrives, `res_vld` is low.
- R8: A zero numerator with the sign flag clear gives 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the pipeline |
| op_vld | input | 1 | Operand pair present this cycle |
| op_neg | input | 1 | Sign flag carried with the numerator (1 = negative) |
| op_num | input | 15 | Unsigned numerator t, t <= op_den |
| op_den | input | 15 | Unsigned denominator D, nonzero |
| res_vld | output | 1 | Result present this cycle |
| res_val | output | 16 | Signed fractional quotient, two's complement |

## Verification
Two behaviours meet in one output cycle: saturation at t = D, and negation by the sign flag. The bench therefore feeds t = D with the flag set and expects 0x8001, a value that depends on both working together. Back-to-back operands are mixed with single-cycle bubbles, so consecutive output cycles alternate between results of different signs and empty slots. Each result is matched against a value computed in software and against its issue time, and every gap is checked to keep `res_vld` low.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
    parameter int unsigned OPW = 15;           // operand and quotient magnitude width
    localparam int unsigned RW  = OPW + 2;     // signed remainder width (covers 2*|r| + D)
    localparam int unsigned OW  = OPW + 1;     // signed result width
    localparam int unsigned LAT = OPW + 1;     // quotient stages plus sign stage

    typedef struct packed {
        logic                 vld;
        logic                 neg;
        logic [OPW-1:0]       den;
        logic signed [RW-1:0] rem;
        logic [OPW-1:0]       qb;
    } lane_t;
endpackage

// File: rtl/nrdiv_step.sv
module nrdiv_step
    import nrdiv_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  lane_t lane_i,
    output lane_t lane_o
);
    lane_t lane_d, lane_q;
    logic signed [RW-1:0] twice;
    logic signed [RW-1:0] dext;

    always_comb begin
        lane_d = lane_i;
        twice  = lane_i.rem <<< 1;
        dext   = signed'({2'b00, lane_i.den});
        // previous bit 1 (rem >= 0): subtract next halved divisor, else add
        if (!lane_i.rem[RW-1]) lane_d.rem = twice - dext;
        else                   lane_d.rem = twice + dext;
        lane_d.qb = {lane_i.qb[OPW-2:0], ~lane_d.rem[RW-1]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lane_q <= '0;
        else        lane_q <= lane_d;
    end

    assign lane_o = lane_q;
endmodule

// File: rtl/nrdiv_sign_out.sv
module nrdiv_sign_out
    import nrdiv_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  lane_t         lane_i,
    output logic          vld_o,
    output logic [OW-1:0] val_o
);
    typedef struct packed {
        logic          vld;
        logic [OW-1:0] val;
    } res_t;

    res_t res_d, res_q;
    logic [OW-1:0] mag;

    always_comb begin
        mag       = {1'b0, lane_i.qb};
        res_d.vld = lane_i.vld;
        res_d.val = lane_i.neg ? (~mag + OW'(1)) : mag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign vld_o = res_q.vld;
    assign val_o = res_q.val;
endmodule

// File: rtl/nrdiv_frac_pipe.sv
module nrdiv_frac_pipe
    import nrdiv_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_vld,
    input  logic        op_neg,
    input  logic [14:0] op_num,
    input  logic [14:0] op_den,
    output logic        res_vld,
    output logic [15:0] res_val
);
    lane_t chain [0:OPW];

    always_comb begin
        chain[0].vld = op_vld;
        chain[0].neg = op_neg;
        chain[0].den = op_den;
        chain[0].rem = signed'({2'b00, op_num});  // first step: 2t - D, i.e. t - D/2
        chain[0].qb  = '0;
    end

    for (genvar k = 0; k < OPW; k++) begin : g_stage
        nrdiv_step u_step (
            .clk    (clk),
            .rst_n  (rst_n),
            .lane_i (chain[k]),
            .lane_o (chain[k+1])
        );
    end

    nrdiv_sign_out u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .lane_i (chain[OPW]),
        .vld_o  (res_vld),
        .val_o  (res_val)
    );
endmodule

// File: rtl/nrdiv_frac_chk.sv
module nrdiv_frac_chk
    import nrdiv_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          op_vld,
    input logic          op_neg,
    input logic [14:0]   op_num,
    input logic          res_vld,
    input logic [15:0]   res_val
);
    logic [LAT-1:0] v_sh, n_sh, z_sh;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_sh <= '0;
            n_sh <= '0;
            z_sh <= '0;
        end else begin
            v_sh <= {v_sh[LAT-2:0], op_vld};
            n_sh <= {n_sh[LAT-2:0], op_neg};
            z_sh <= {z_sh[LAT-2:0], (op_num == '0)};
        end
    end

    // R5 / R6: result valid exactly LAT cycles after capture
    p_valid_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld == v_sh[LAT-1]);

    // R7: nothing emerges right after reset is applied
    p_quiet_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !res_vld);

    // R3: clear sign never yields a negative value
    p_pos_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !n_sh[LAT-1]) |-> !res_val[15]);

    // R3: set sign yields a non-positive value
    p_neg_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && n_sh[LAT-1]) |-> (res_val[15] || res_val == 16'h0000));

    // R2: magnitude saturates, never reaching -1.0
    p_no_minus_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> res_val != 16'h8000);

    // R4 / R8: zero numerator gives zero
    p_zero_num_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && z_sh[LAT-1]) |-> res_val == 16'h0000);
endmodule

bind nrdiv_frac_pipe nrdiv_frac_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_vld  (op_vld),
    .op_neg  (op_neg),
    .op_num  (op_num),
    .res_vld (res_vld),
    .res_val (res_val)
);

// File: tb/nrdiv_frac_pipe_test.sv
`timescale 1ns/1ps
module nrdiv_frac_pipe_test;
    localparam int LATENCY = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_vld = 1'b0;
    logic        op_neg = 1'b0;
    logic [14:0] op_num = '0;
    logic [14:0] op_den = 15'd1;
    logic        res_vld;
    logic [15:0] res_val;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 0;

    logic [15:0] exp_q[$];
    int          when_q[$];
    string       tag_q[$];

    nrdiv_frac_pipe uut (
        .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_neg(op_neg),
        .op_num(op_num), .op_den(op_den), .res_vld(res_vld), .res_val(res_val)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] model(input bit neg, input int t, input int d);
        int q;
        q = (t * 32768) / d;
        if (q > 32767) q = 32767;
        if (neg) q = -q;
        return q[15:0];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    // called at negedge: look at outputs first
    task automatic observe();
        if (res_vld) begin
            if (exp_q.size() == 0) begin
                check(0, "R6 unexpected result", 1, 0);
            end else begin
                logic [15:0] e;
                int w;
                string tg;
                e = exp_q.pop_front();
                w = when_q.pop_front();
                tg = tag_q.pop_front();
                check(res_val == e, tg, res_val, e);
                check(cyc - w == LATENCY, "R5 latency", cyc - w, LATENCY);
            end
        end else if (when_q.size() != 0 && cyc - when_q[0] >= LATENCY) begin
            check(0, "R6 missing result", 0, 1);
            void'(exp_q.pop_front());
            void'(when_q.pop_front());
            void'(tag_q.pop_front());
        end
    endtask

    task automatic issue(input bit v, input bit neg, input int t, input int d);
        @(negedge clk);
        observe();
        op_vld = v;
        op_neg = neg;
        op_num = t[14:0];
        op_den = d[14:0];
        if (v) begin
            string tg;
            if (t == d)       tg = "R2 saturation";
            else if (t == 0)  tg = neg ? "R4 negative zero" : "R8 zero";
            else if (neg)     tg = "R3 negation";
            else              tg = "R1 quotient";
            exp_q.push_back(model(neg, t, d));
            when_q.push_back(cyc);
            tag_q.push_back(tg);
        end
    endtask

    initial begin
        int seed;
        int d;
        int t;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        repeat (4) @(negedge clk);
        check(res_vld == 1'b0, "R7 during reset", res_vld, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(res_vld == 1'b0, "R7 after release", res_vld, 0);
        // directed corners
        issue(1, 0, 16'h39D3, 16'h43D7);
        issue(1, 1, 16'h39D3, 16'h43D7);
        issue(1, 0, 32767, 32767);
        issue(1, 1, 32767, 32767);
        issue(0, 0, 0, 1);
        issue(1, 1, 1, 1);
        issue(1, 0, 0, 100);
        issue(1, 1, 0, 32767);
        issue(0, 1, 5, 9);
        issue(1, 0, 32766, 32767);
        issue(1, 1, 1, 32767);
        issue(1, 0, 1, 2);
        issue(1, 1, 16384, 32767);
        // constrained random with bubbles
        for (int i = 0; i < 3000; i++) begin
            d = 1 + ($urandom % 32767);
            t = $urandom % (d + 1);
            issue(($urandom % 4) != 0, $urandom % 2, t, d);
        end
        issue(0, 0, 0, 1);
        repeat (LATENCY + 4) begin
            @(negedge clk);
            observe();
        end
        check(exp_q.size() == 0, "R6 drained", exp_q.size(), 0);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule